// File: doc/BRIEF.md
# Debounced Level-Interrupt Input Bank

This block watches a bank of external input pins, cleans each one up and turns the cleaned levels into interrupts. Every pin first crosses into the block clock through a two-flop synchroniser. A per-channel filter then counts pulses of a slow millisecond tick, and only moves the filtered level once the pin has held its new value for the programmed number of ticks. A channel that is programmed with length zero skips the filter. Every channel is input only. No register can make a pin drive.

Software controls the bank through a plain 32-bit register port: an address, a write strobe, write data, and read data that is decoded from the address in the same cycle. A channel raises an interrupt only after software arms it with a one-shot trigger write. An armed channel latches a raw status bit when its filtered level matches the selected polarity (high or low). The arm is then consumed. The enabled status bits are ORed together onto one active-low interrupt pin. Software acknowledges an event by writing ones to the clear register, and re-arms the channel if it wants another event. The register port has no valid/ready stage because every access finishes in one cycle. A write takes effect at the clock edge on which `bus_wr` is high. A read returns data while the address is held.

Top module: `lvl_irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_n` is 1. Any address that is not in the map reads 0. The map is: data 0x00, data mask 0x04, polarity 0x14, enable 0x18, raw status 0x1C, masked status 0x20, clear 0x24, trigger 0x28, and channel n control at 0x40+4n. In every bit-vector register, bit n belongs to channel n.
- R2: The data mask, polarity and enable registers keep only bits 15:0. A channel control register keeps only bits 11:0, which hold the debounce length in ticks. All other bits read as 0.
- R3: Writes to the data, raw status and masked status registers have no effect. The pins stay input only, and the read values do not change.
- R4: Bit n of the data register returns channel n's filtered level while data-mask bit n is 1. It reads 0 while that mask bit is 0.
- R5: With length 0, the filtered level follows the pin 3 clock edges after the pin changes. With length L > 0, the filtered level takes the new value on the L-th tick that arrives while the synchronised pin differs from it. Any return to the old level restarts that count.
- R6: Writing 1 to trigger bit n arms channel n. The trigger register always reads 0. An armed channel whose filtered level equals its polarity bit (1 = high, 0 = low) sets raw status bit n one edge later and disarms. It raises no further status until it is triggered again.
- R7: The masked status equals raw status AND enable. `irq_n` is 0 exactly when masked status is non-zero.
- R8: Writing 1 to clear bit n clears raw bit n, and writing 0 leaves it unchanged. When a clear meets a new status set on the same edge, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond that paces the debounce counters |
| pin_in | input | 16 | Asynchronous external input pins |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, in the same cycle |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
Two functions can land on the same edge: a channel latching a new status bit, and a software clear of that same bit. The bench provokes this by writing the trigger bit and then, on the very next edge, the clear bit for a channel whose level already matches its polarity. On that next edge the armed channel sets its status. The status must still read 1 afterwards, and a second clear must then bring it to 0. A second overlap is also exercised: a change of polarity that turns an already-armed, idle channel into a firing one.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_DATA  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DMASK = 8'h04;
  localparam logic [ADDR_W-1:0] A_POL   = 8'h14;
  localparam logic [ADDR_W-1:0] A_IEN   = 8'h18;
  localparam logic [ADDR_W-1:0] A_RAW   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_MIS   = 8'h20;
  localparam logic [ADDR_W-1:0] A_CLR   = 8'h24;
  localparam logic [ADDR_W-1:0] A_TRIG  = 8'h28;
  localparam logic [ADDR_W-1:0] A_CTRL0 = 8'h40;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/lvl_irq_chan.sv
module lvl_irq_chan #(
  parameter int DBNC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pin_s,
  input  logic [DBNC_W-1:0] len,
  input  logic              pol,
  input  logic              arm_req,
  input  logic              clr_req,
  output logic              level,
  output logic              armed,
  output logic              raw,
  output logic              hit
);
  localparam logic [DBNC_W:0] ONE = (DBNC_W+1)'(1);

  logic [DBNC_W-1:0] cnt;
  logic [DBNC_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + ONE;
  assign hit     = armed & (level == pol);

  // debounce filter: counts ticks while the synced pin disagrees
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (pin_s == level) begin
      cnt <= '0;
    end else if (len == '0) begin
      level <= pin_s;
    end else if (tick) begin
      if (cnt_nxt >= {1'b0, len}) begin
        level <= pin_s;
        cnt   <= '0;
      end else begin
        cnt <= cnt_nxt[DBNC_W-1:0];
      end
    end
  end

  // arm / status: a fresh trigger and a fresh set both win over removal
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      raw   <= 1'b0;
    end else begin
      armed <= arm_req | (armed & ~hit);
      raw   <= hit | (raw & ~clr_req);
    end
  end
endmodule

// File: rtl/lvl_irq_bank.sv
module lvl_irq_bank
  import lvl_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DBNC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic [NUM_CH-1:0] pin_in,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_n
);
  localparam int KEEP_W = (NUM_CH > DBNC_W) ? NUM_CH : DBNC_W;

  logic [NUM_CH-1:0] pin_s;
  logic [NUM_CH-1:0] dmask_q, pol_q, ien_q;
  logic [NUM_CH-1:0] level_vec, armed_vec, raw_vec, hit_vec;
  logic [NUM_CH-1:0] arm_vec, clr_vec;
  logic [DBNC_W-1:0] len_q [NUM_CH];
  logic              unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:KEEP_W];

  lvl_irq_sync #(.W(NUM_CH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .d_sync  (pin_s)
  );

  // one-shot strobes
  assign arm_vec = (bus_wr && bus_addr == A_TRIG) ? bus_wdata[NUM_CH-1:0] : '0;
  assign clr_vec = (bus_wr && bus_addr == A_CLR)  ? bus_wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmask_q <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DMASK) dmask_q <= bus_wdata[NUM_CH-1:0];
      if (bus_addr == A_POL)   pol_q   <= bus_wdata[NUM_CH-1:0];
      if (bus_addr == A_IEN)   ien_q   <= bus_wdata[NUM_CH-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(A_CTRL0 + 4*i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q[i] <= '0;
      else if (bus_wr && bus_addr == CTRL_A) len_q[i] <= bus_wdata[DBNC_W-1:0];
    end

    lvl_irq_chan #(.DBNC_W(DBNC_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_ms),
      .pin_s   (pin_s[i]),
      .len     (len_q[i]),
      .pol     (pol_q[i]),
      .arm_req (arm_vec[i]),
      .clr_req (clr_vec[i]),
      .level   (level_vec[i]),
      .armed   (armed_vec[i]),
      .raw     (raw_vec[i]),
      .hit     (hit_vec[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_DATA:  bus_rdata = DATA_W'(level_vec & dmask_q);
      A_DMASK: bus_rdata = DATA_W'(dmask_q);
      A_POL:   bus_rdata = DATA_W'(pol_q);
      A_IEN:   bus_rdata = DATA_W'(ien_q);
      A_RAW:   bus_rdata = DATA_W'(raw_vec);
      A_MIS:   bus_rdata = DATA_W'(raw_vec & ien_q);
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (bus_addr == ADDR_W'(A_CTRL0 + 4*i)) bus_rdata = DATA_W'(len_q[i]);
        end
      end
    endcase
  end

  assign irq_n = ~|(raw_vec & ien_q);
endmodule

// File: rtl/lvl_irq_bank_chk.sv
module lvl_irq_bank_chk
  import lvl_irq_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              irq_n,
  input logic [NUM_CH-1:0] raw_vec,
  input logic [NUM_CH-1:0] armed_vec,
  input logic [NUM_CH-1:0] hit_vec,
  input logic [NUM_CH-1:0] ien_q,
  input logic [NUM_CH-1:0] dmask_q
);
  // R7: with nothing enabled the interrupt pin stays high
  p_quiet_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> irq_n);

  // R7: masked status never shows a disabled channel
  p_mis_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MIS) |-> ((bus_rdata[NUM_CH-1:0] & ~ien_q) == '0));

  // R6: a status bit only rises on a channel that was armed
  p_arm_before_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vec & ~$past(raw_vec) & ~$past(armed_vec)) == '0);

  // R6: trigger register reads as zero
  p_trig_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_TRIG) |-> (bus_rdata == '0));

  // R8: a cleared bit with no competing set is gone next cycle
  p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=>
      ((raw_vec & $past(bus_wdata[NUM_CH-1:0] & ~hit_vec)) == '0));

  // R4: masked-off channels read zero
  p_data_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DATA) |-> ((bus_rdata[NUM_CH-1:0] & ~dmask_q) == '0));
endmodule

bind lvl_irq_bank lvl_irq_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_n     (irq_n),
  .raw_vec   (raw_vec),
  .armed_vec (armed_vec),
  .hit_vec   (hit_vec),
  .ien_q     (ien_q),
  .dmask_q   (dmask_q)
);

// File: tb/lvl_irq_bank_test.sv
module lvl_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b0;
  logic [15:0] pin_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  lvl_irq_bank uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pin_in(pin_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // vector: {write, addr, wdata, expected read of addr, requirement number}
  localparam int NV = 11;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 8'h04, 32'h0,         32'h0,        4'd1}, // R1 mask after reset
    {1'b0, 8'h40, 32'h0,         32'h0,        4'd1}, // R1 control after reset
    {1'b0, 8'h3C, 32'h0,         32'h0,        4'd1}, // R1 unmapped
    {1'b0, 8'h80, 32'h0,         32'h0,        4'd1}, // R1 unmapped past controls
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_FFFF, 4'd2}, // R2 mask width
    {1'b1, 8'h14, 32'h1234_A5A5, 32'h0000_A5A5, 4'd2}, // R2 polarity width
    {1'b1, 8'h48, 32'hFFFF_F123, 32'h0000_0123, 4'd2}, // R2 control width
    {1'b1, 8'h00, 32'h0000_FFFF, 32'h0,        4'd3}, // R3 data write ignored
    {1'b1, 8'h1C, 32'h0000_FFFF, 32'h0,        4'd3}, // R3 raw write ignored
    {1'b1, 8'h20, 32'h0000_FFFF, 32'h0,        4'd3}, // R3 masked write ignored
    {1'b1, 8'h28, 32'h0,         32'h0,        4'd6}  // R6 trigger reads zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick;
    tick_ms = 1'b1; @(posedge clk); @(negedge clk); tick_ms = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cycles(3);
    check("R1 irq_n in reset", {31'b0, irq_n}, 32'h1);
    rst_n = 1'b1;
    cycles(1);
    check("R1 irq_n after reset", {31'b0, irq_n}, 32'h1);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][76]) wr(VEC[k][75:68], VEC[k][67:36]);
      rd(VEC[k][75:68], rv);
      check($sformatf("R%0d vector %0d", VEC[k][3:0], k), rv, VEC[k][35:4]);
    end

    wr(8'h14, 32'h0);
    // R5 bypass: channel 0 length 0, three edges to follow
    pin_in[0] = 1'b1;
    cycles(2);
    rd(8'h00, rv); check("R5 bypass after 2 edges", rv & 32'h1, 32'h0);
    cycles(1);
    rd(8'h00, rv); check("R5 bypass after 3 edges", rv & 32'h1, 32'h1);

    // R4 mask gating
    wr(8'h04, 32'hFFFE);
    rd(8'h00, rv); check("R4 masked channel reads 0", rv & 32'h1, 32'h0);
    wr(8'h04, 32'hFFFF);
    rd(8'h00, rv); check("R4 unmasked channel reads level", rv & 32'h1, 32'h1);

    // R5 debounce: channel 3, length 3 ticks
    wr(8'h4C, 32'h3);
    pin_in[3] = 1'b1;
    cycles(4);
    rd(8'h00, rv); check("R5 no ticks no change", rv & 32'h8, 32'h0);
    tick(); tick();
    rd(8'h00, rv); check("R5 two of three ticks", rv & 32'h8, 32'h0);
    tick();
    rd(8'h00, rv); check("R5 third tick", rv & 32'h8, 32'h8);
    pin_in[3] = 1'b0; cycles(4);
    tick(); tick();
    pin_in[3] = 1'b1; cycles(4);
    pin_in[3] = 1'b0; cycles(4);
    tick(); tick();
    rd(8'h00, rv); check("R5 count restarted by bounce", rv & 32'h8, 32'h8);
    tick();
    rd(8'h00, rv); check("R5 falls after full count", rv & 32'h8, 32'h0);

    // R6/R7: channel 5 high polarity
    pin_in[5] = 1'b1; cycles(4);
    wr(8'h14, 32'h20);
    wr(8'h18, 32'h20);
    cycles(3);
    rd(8'h1C, rv); check("R6 no status before trigger", rv, 32'h0);
    wr(8'h28, 32'h20);
    rd(8'h1C, rv); check("R6 status one edge after arm", rv, 32'h0);
    cycles(1);
    rd(8'h1C, rv); check("R6 raw set", rv, 32'h20);
    rd(8'h20, rv); check("R7 masked set", rv, 32'h20);
    check("R7 irq_n low", {31'b0, irq_n}, 32'h0);
    wr(8'h24, 32'h0);
    rd(8'h1C, rv); check("R8 zero clear no effect", rv, 32'h20);
    wr(8'h24, 32'h20);
    rd(8'h1C, rv); check("R8 clear", rv, 32'h0);
    check("R7 irq_n released", {31'b0, irq_n}, 32'h1);
    cycles(3);
    rd(8'h1C, rv); check("R6 one event per trigger", rv, 32'h0);

    // R7 enable gating
    wr(8'h28, 32'h20); cycles(1);
    wr(8'h18, 32'h0);
    rd(8'h20, rv); check("R7 disabled masked", rv, 32'h0);
    rd(8'h1C, rv); check("R7 raw kept while disabled", rv, 32'h20);
    check("R7 irq_n high when disabled", {31'b0, irq_n}, 32'h1);
    wr(8'h18, 32'h20);
    check("R7 irq_n on re-enable", {31'b0, irq_n}, 32'h0);
    wr(8'h24, 32'h20);

    // R6 low polarity on channel 6 (pin low), first armed with high polarity
    wr(8'h14, 32'h60);
    wr(8'h28, 32'h40);
    cycles(3);
    rd(8'h1C, rv); check("R6 polarity mismatch no status", rv, 32'h0);
    wr(8'h14, 32'h20);
    cycles(1);
    rd(8'h1C, rv); check("R6 low polarity fires", rv, 32'h40);
    wr(8'h24, 32'h40);

    // R8 collision: set and clear on the same edge
    wr(8'h28, 32'h20);
    wr(8'h24, 32'h20);
    rd(8'h1C, rv); check("R8 set wins over clear", rv, 32'h20);
    wr(8'h24, 32'h20);
    rd(8'h1C, rv); check("R8 later clear", rv, 32'h0);
    check("R7 final irq_n", {31'b0, irq_n}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule